// File: doc/BRIEF.md
# Thread Context Register Access Checker

This block sits in front of the register window that holds one hardware thread's interrupt management context. Each access request carries an offset, a byte size, a direction and the privilege level of the page it came through. The block decides how to handle the access and registers the decision. It can send the access to one entry of a fixed operation table. It can let the access through as a plain register access. It can also reject the access as an error, and for a rejected read it asks the read path to return all ones. The operation handlers and the register storage sit outside this block. They use the index and the enables that this block produces.

The window holds four rings at 16-byte spacing: user, OS, pool and physical, as ring numbers 0 to 3 in offset bits [5:4]. Offset bit 11 marks the special-operation region. Each ring supplies the byte that holds its valid bit. Ownership is chained. A ring counts as hardware-owned only while every ring from it up to the physical ring is valid. Some uses are not legal for the current owner. These raise an undefined flag, but the access still goes ahead, so the error logging downstream can report them without changing behaviour.

Top module: `tcr_access_check`

## Requirements
- R1: While reset is held, and in the first cycle after it, opHit, opSel, rawEn, errFlag, undefFlag and rdOnes are all zero.
- R2: Ring r counts as owned exactly when bit 7 is set in the ringWord2 byte [8r+7:8r] of ring r and of every ring above it, up to ring 3.
- R3: When offset bit 11 is set, an access that matches a table entry (R10) raises opHit with opSel set to the entry index. An access that matches no entry raises errFlag, and also raises rdOnes when it is a read.
- R4: When offset bit 11 is clear, a table match takes precedence over raw access: opHit is raised and rawEn stays low.
- R5: For a table hit, undefFlag is raised when the ring is owned and the entry lacks hardware permission, or when the ring is not owned and the entry lacks software permission. opHit is raised all the same.
- R6: Below the special region, with no table hit, a raw access is rejected (errFlag high, rdOnes high for a read, rawEn low) when the size is under 4, the ring is 0, or no addressed byte allows the direction under R7. Otherwise rawEn is raised.
- R7: The byte permission code has bit 1 for read and bit 0 for write. The code is 3 on: ring 0 bytes 0 and 8-11. Ring 1 bytes 0-5, 8-11 and 15. Ring 2 bytes 2, 3, 5, 6 and 9-11. Ring 3 bytes 0-3, 5, 8 and 11. The code is 2 on byte 7 of rings 1 and 3. The hardware view (level 3) adds code 3 on ring 2 byte 8 and ring 3 bytes 12-14. Every other byte is 0. An access covers the bytes from offset[3:0] up to offset[3:0]+size-1, and only bytes below 16 count.
- R8: An accepted raw write to an owned ring raises undefFlag. rawEn stays high.
- R9: Outputs show the decision for the request of the previous cycle. After a cycle with reqValid low, all flags and opSel are zero.
- R10: The levels are 0 user, 1 OS, 2 hypervisor, 3 hardware. An entry matches when the request's level is at least the entry's level and the offset, size and direction are all equal. Entries are listed as index: level, offset, size, direction, hw-ok, sw-ok. 0: 1,0x013,1,W,1,1. 1: 2,0x018,4,W,1,1. 2: 2,0x033,1,W,1,1. 3: 2,0x038,1,W,0,1. 4: 2,0x038,1,R,1,1. 5: 1,0x810,2,R,1,0. 6: 1,0x818,1,W,1,0. 7: 2,0x818,4,R,1,0. 8: 2,0x830,2,R,1,0. 9: 2,0x828,4,R,1,0. 10: 2,0x838,1,R,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present this cycle |
| reqOffset | input | OFF_W (12) | Byte offset in the window |
| reqSize | input | SIZE_W (4) | Access size in bytes (1, 2, 4, 8) |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqLevel | input | 2 | Page privilege level of the access |
| ringWord2 | input | 8*NUM_RINGS (32) | Valid byte of each ring; ring r at [8r+7:8r] |
| opHit | output | 1 | Access selects a table operation |
| opSel | output | OP_IDX_W (4) | Index of the selected operation |
| rawEn | output | 1 | Raw register access allowed |
| errFlag | output | 1 | Access rejected |
| undefFlag | output | 1 | Access is undefined for the ring's owner |
| rdOnes | output | 1 | Read data must be forced to all ones |

## Verification
Some properties are checked on every cycle. The outcomes are exclusive. A forced all-ones read always comes with an error. Idle cycles clear the outputs. Special-region, user-ring and short accesses never become raw accesses. An undefined flag always belongs to an operation or a raw access. Raw accesses with the physical ring invalid are never flagged undefined. The bench covers what needs a reference decision. It sweeps every offset of both regions at every size, direction and level, under valid-byte patterns that break the ownership chain at different rings. This shows the table priority, the level rule, the byte permission view and the owner-dependent undefined flag.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  localparam int NUM_OPS  = 11;
  localparam int OP_IDX_W = $clog2(NUM_OPS);

  typedef struct packed {
    logic [1:0]  minLvl;
    logic [15:0] offs;
    logic [3:0]  bytes;
    logic        wr;
    logic        hwOk;
    logic        swOk;
  } opEntryT;

  typedef struct packed {
    logic                hit;
    logic [OP_IDX_W-1:0] idx;
    logic                raw;
    logic                err;
    logic                undef;
    logic                ones;
  } strobeT;

  // Operation table; lowest index wins on overlap.
  function automatic opEntryT opEntry(input int idx);
    opEntryT e;
    e = '0;
    case (idx)
      0:  e = '{2'd1, 16'h013, 4'd1, 1'b1, 1'b1, 1'b1};
      1:  e = '{2'd2, 16'h018, 4'd4, 1'b1, 1'b1, 1'b1};
      2:  e = '{2'd2, 16'h033, 4'd1, 1'b1, 1'b1, 1'b1};
      3:  e = '{2'd2, 16'h038, 4'd1, 1'b1, 1'b0, 1'b1};
      4:  e = '{2'd2, 16'h038, 4'd1, 1'b0, 1'b1, 1'b1};
      5:  e = '{2'd1, 16'h810, 4'd2, 1'b0, 1'b1, 1'b0};
      6:  e = '{2'd1, 16'h818, 4'd1, 1'b1, 1'b1, 1'b0};
      7:  e = '{2'd2, 16'h818, 4'd4, 1'b0, 1'b1, 1'b0};
      8:  e = '{2'd2, 16'h830, 4'd2, 1'b0, 1'b1, 1'b0};
      9:  e = '{2'd2, 16'h828, 4'd4, 1'b0, 1'b1, 1'b0};
      10: e = '{2'd2, 16'h838, 4'd1, 1'b0, 1'b1, 1'b0};
      default: e = '0;
    endcase
    return e;
  endfunction

  // Byte permission code: bit 1 read allowed, bit 0 write allowed.
  function automatic logic [1:0] permCode(input logic hwView, input logic [1:0] ring,
                                          input logic [3:0] b);
    logic [1:0] c;
    c = 2'd0;
    case (ring)
      2'd0: if (b == 4'd0 || (b >= 4'd8 && b <= 4'd11)) c = 2'd3;
      2'd1: begin
        if (b <= 4'd5 || (b >= 4'd8 && b <= 4'd11) || b == 4'd15) c = 2'd3;
        else if (b == 4'd7) c = 2'd2;
      end
      2'd2: begin
        if (b == 4'd2 || b == 4'd3 || b == 4'd5 || b == 4'd6 ||
            (b >= 4'd9 && b <= 4'd11)) c = 2'd3;
        else if (b == 4'd8 && hwView) c = 2'd3;
      end
      default: begin
        if (b <= 4'd3 || b == 4'd5 || b == 4'd8 || b == 4'd11) c = 2'd3;
        else if (b == 4'd7) c = 2'd2;
        else if (b >= 4'd12 && b <= 4'd14 && hwView) c = 2'd3;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tcr_own_chain.sv
module tcr_own_chain #(
  parameter int NUM_RINGS = 4
) (
  input  logic [8*NUM_RINGS-1:0] ringWord2,
  output logic [NUM_RINGS-1:0]   owned
);
  localparam int TOP = NUM_RINGS - 1;

  assign owned[TOP] = ringWord2[8*TOP+7];

  generate
    for (genvar r = 0; r < TOP; r++) begin : g_chain
      assign owned[r] = ringWord2[8*r+7] & owned[r+1];
    end
  endgenerate
endmodule

// File: rtl/tcr_datapath.sv
module tcr_datapath
  import tcr_pkg::*;
#(
  parameter int OFF_W      = 12,
  parameter int SIZE_W     = 4,
  parameter int NUM_RINGS  = 4,
  parameter int RING_BYTES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic                reqWrite,
  input  logic [1:0]          reqLevel,
  output logic                matchHit,
  output logic [OP_IDX_W-1:0] matchIdx,
  output logic                matchHwOk,
  output logic                matchSwOk,
  output logic                permAny,
  input  strobeT              strobe,
  output logic                opHit,
  output logic [OP_IDX_W-1:0] opSel,
  output logic                rawEn,
  output logic                errFlag,
  output logic                undefFlag,
  output logic                rdOnes
);
  localparam int RING_LSB = $clog2(RING_BYTES);
  localparam int RING_W   = $clog2(NUM_RINGS);

  logic [RING_W-1:0] ring;
  logic              hwView;

  assign ring   = reqOffset[RING_LSB +: RING_W];
  assign hwView = (reqLevel == 2'd3);

  // Table match, scanned downward so the lowest index is kept.
  always_comb begin
    opEntryT e;
    matchHit  = 1'b0;
    matchIdx  = '0;
    matchHwOk = 1'b0;
    matchSwOk = 1'b0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      e = opEntry(i);
      if (reqLevel >= e.minLvl && reqOffset == OFF_W'(e.offs) &&
          reqSize == SIZE_W'(e.bytes) && reqWrite == e.wr) begin
        matchHit  = 1'b1;
        matchIdx  = OP_IDX_W'(i);
        matchHwOk = e.hwOk;
        matchSwOk = e.swOk;
      end
    end
  end

  // Any covered byte allowing this direction.
  always_comb begin
    int loB;
    int hiB;
    logic [1:0] code;
    loB = int'(reqOffset[RING_LSB-1:0]);
    hiB = loB + int'(reqSize);
    permAny = 1'b0;
    for (int b = 0; b < RING_BYTES; b++) begin
      code = permCode(hwView, 2'(ring), 4'(b));
      if (b >= loB && b < hiB)
        permAny = permAny | (reqWrite ? code[0] : code[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opHit     <= 1'b0;
      opSel     <= '0;
      rawEn     <= 1'b0;
      errFlag   <= 1'b0;
      undefFlag <= 1'b0;
      rdOnes    <= 1'b0;
    end else begin
      opHit     <= strobe.hit;
      opSel     <= strobe.idx;
      rawEn     <= strobe.raw;
      errFlag   <= strobe.err;
      undefFlag <= strobe.undef;
      rdOnes    <= strobe.ones;
    end
  end
endmodule

// File: rtl/tcr_control.sv
module tcr_control
  import tcr_pkg::*;
#(
  parameter int NUM_RINGS    = 4,
  parameter int SIZE_W       = 4,
  parameter int MIN_RAW_SIZE = 4
) (
  input  logic                        reqValid,
  input  logic                        special,
  input  logic [$clog2(NUM_RINGS)-1:0] ring,
  input  logic [SIZE_W-1:0]           reqSize,
  input  logic                        reqWrite,
  input  logic [NUM_RINGS-1:0]        owned,
  input  logic                        matchHit,
  input  logic [OP_IDX_W-1:0]         matchIdx,
  input  logic                        matchHwOk,
  input  logic                        matchSwOk,
  input  logic                        permAny,
  output strobeT                      strobe
);
  logic ringOwned;
  logic rawReject;

  assign ringOwned = owned[ring];
  assign rawReject = (reqSize < SIZE_W'(MIN_RAW_SIZE)) || (ring == '0) || !permAny;

  always_comb begin
    strobe = '0;
    if (reqValid) begin
      if (matchHit) begin
        strobe.hit   = 1'b1;
        strobe.idx   = matchIdx;
        strobe.undef = ringOwned ? !matchHwOk : !matchSwOk;
      end else if (special || rawReject) begin
        strobe.err  = 1'b1;
        strobe.ones = !reqWrite;
      end else begin
        strobe.raw   = 1'b1;
        strobe.undef = reqWrite && ringOwned;
      end
    end
  end
endmodule

// File: rtl/tcr_access_check.sv
module tcr_access_check
  import tcr_pkg::*;
#(
  parameter int OFF_W        = 12,
  parameter int SIZE_W       = 4,
  parameter int NUM_RINGS    = 4,
  parameter int RING_BYTES   = 16,
  parameter int SPECIAL_BIT  = 11,
  parameter int MIN_RAW_SIZE = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [OFF_W-1:0]         reqOffset,
  input  logic [SIZE_W-1:0]        reqSize,
  input  logic                     reqWrite,
  input  logic [1:0]               reqLevel,
  input  logic [8*NUM_RINGS-1:0]   ringWord2,
  output logic                     opHit,
  output logic [OP_IDX_W-1:0]      opSel,
  output logic                     rawEn,
  output logic                     errFlag,
  output logic                     undefFlag,
  output logic                     rdOnes
);
  localparam int RING_LSB = $clog2(RING_BYTES);
  localparam int RING_W   = $clog2(NUM_RINGS);

  logic [NUM_RINGS-1:0] owned;
  logic                 matchHit;
  logic [OP_IDX_W-1:0]  matchIdx;
  logic                 matchHwOk;
  logic                 matchSwOk;
  logic                 permAny;
  strobeT               strobe;

  tcr_own_chain #(.NUM_RINGS(NUM_RINGS)) u_own (
    .ringWord2(ringWord2),
    .owned    (owned)
  );

  tcr_control #(
    .NUM_RINGS(NUM_RINGS), .SIZE_W(SIZE_W), .MIN_RAW_SIZE(MIN_RAW_SIZE)
  ) u_ctrl (
    .reqValid (reqValid),
    .special  (reqOffset[SPECIAL_BIT]),
    .ring     (reqOffset[RING_LSB +: RING_W]),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .owned    (owned),
    .matchHit (matchHit),
    .matchIdx (matchIdx),
    .matchHwOk(matchHwOk),
    .matchSwOk(matchSwOk),
    .permAny  (permAny),
    .strobe   (strobe)
  );

  tcr_datapath #(
    .OFF_W(OFF_W), .SIZE_W(SIZE_W), .NUM_RINGS(NUM_RINGS), .RING_BYTES(RING_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqLevel (reqLevel),
    .matchHit (matchHit),
    .matchIdx (matchIdx),
    .matchHwOk(matchHwOk),
    .matchSwOk(matchSwOk),
    .permAny  (permAny),
    .strobe   (strobe),
    .opHit    (opHit),
    .opSel    (opSel),
    .rawEn    (rawEn),
    .errFlag  (errFlag),
    .undefFlag(undefFlag),
    .rdOnes   (rdOnes)
  );
endmodule

// File: rtl/tcr_access_check_sva.sv
module tcr_access_check_sva
  import tcr_pkg::*;
#(
  parameter int OFF_W        = 12,
  parameter int SIZE_W       = 4,
  parameter int NUM_RINGS    = 4,
  parameter int RING_BYTES   = 16,
  parameter int SPECIAL_BIT  = 11,
  parameter int MIN_RAW_SIZE = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [OFF_W-1:0]       reqOffset,
  input logic [SIZE_W-1:0]      reqSize,
  input logic                   reqWrite,
  input logic [8*NUM_RINGS-1:0] ringWord2,
  input logic                   opHit,
  input logic                   rawEn,
  input logic                   errFlag,
  input logic                   undefFlag,
  input logic                   rdOnes
);
  localparam int RING_LSB = $clog2(RING_BYTES);
  localparam int RING_W   = $clog2(NUM_RINGS);

  // R3/R6: all-ones read only comes with an error
  p_ones_with_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdOnes |-> errFlag);

  // R4: outcomes are exclusive
  p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({opHit, rawEn, errFlag}));

  // R9: idle cycle clears the outputs
  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(opHit || rawEn || errFlag || undefFlag || rdOnes));

  // R3: special region is never a raw access
  p_special_no_raw_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOffset[SPECIAL_BIT]) |=> !rawEn);

  // R6: user ring and short accesses are never raw
  p_user_ring_raw_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOffset[RING_LSB +: RING_W] == '0) |=> !rawEn);
  p_short_raw_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize < SIZE_W'(MIN_RAW_SIZE)) |=> !rawEn);

  // R3: writes never ask for an all-ones read
  p_write_no_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> !rdOnes);

  // R5/R8: undefined always belongs to an operation or raw access
  p_undef_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    undefFlag |-> (opHit || rawEn));

  // R2/R8: with the top ring invalid no ring is owned, so raw is never undefined
  p_unowned_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ringWord2[8*NUM_RINGS-1]) |=> !(rawEn && undefFlag));
endmodule

bind tcr_access_check tcr_access_check_sva #(
  .OFF_W(OFF_W), .SIZE_W(SIZE_W), .NUM_RINGS(NUM_RINGS), .RING_BYTES(RING_BYTES),
  .SPECIAL_BIT(SPECIAL_BIT), .MIN_RAW_SIZE(MIN_RAW_SIZE)
) u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
  .reqSize(reqSize), .reqWrite(reqWrite), .ringWord2(ringWord2),
  .opHit(opHit), .rawEn(rawEn), .errFlag(errFlag), .undefFlag(undefFlag),
  .rdOnes(rdOnes)
);

// File: tb/test_tcr_access_check.sv
`timescale 1ns/1ps
module test_tcr_access_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [11:0] reqOffset = '0;
  logic [3:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqLevel = '0;
  logic [31:0] ringWord2 = '0;
  logic        opHit, rawEn, errFlag, undefFlag, rdOnes;
  logic [3:0]  opSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tcr_access_check i_tcr_access_check (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqLevel(reqLevel),
    .ringWord2(ringWord2), .opHit(opHit), .opSel(opSel), .rawEn(rawEn),
    .errFlag(errFlag), .undefFlag(undefFlag), .rdOnes(rdOnes)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s off=%h sz=%0d wr=%0b lvl=%0d w2=%h actual=%h expected=%h",
               tag, reqOffset, reqSize, reqWrite, reqLevel, ringWord2, act, exp);
    end
  endtask

  // R10 table, written per access shape
  task automatic lookOp(input logic [11:0] off, input logic [3:0] sz, input logic wr,
                        input logic [1:0] lvl, output logic hit, output logic [3:0] idx,
                        output logic hw, output logic sw);
    logic [1:0] need;
    hit = 1'b1; need = 2'd2; hw = 1'b1; sw = 1'b0; idx = 4'd0;
    if (wr && off == 12'h013 && sz == 1)       begin idx = 0;  need = 1; sw = 1; end
    else if (wr && off == 12'h018 && sz == 4)  begin idx = 1;  sw = 1; end
    else if (wr && off == 12'h033 && sz == 1)  begin idx = 2;  sw = 1; end
    else if (wr && off == 12'h038 && sz == 1)  begin idx = 3;  sw = 1; hw = 0; end
    else if (!wr && off == 12'h038 && sz == 1) begin idx = 4;  sw = 1; end
    else if (!wr && off == 12'h810 && sz == 2) begin idx = 5;  need = 1; end
    else if (wr && off == 12'h818 && sz == 1)  begin idx = 6;  need = 1; end
    else if (!wr && off == 12'h818 && sz == 4) begin idx = 7;  end
    else if (!wr && off == 12'h830 && sz == 2) begin idx = 8;  end
    else if (!wr && off == 12'h828 && sz == 4) begin idx = 9;  end
    else if (!wr && off == 12'h838 && sz == 1) begin idx = 10; end
    else hit = 1'b0;
    if (lvl < need) begin hit = 1'b0; idx = 0; end
  endtask

  // R7 byte masks per ring and direction
  function automatic logic [15:0] byteMask(input logic [1:0] ring, input logic wr,
                                          input logic hwv);
    case (ring)
      2'd0: return 16'h0F01;
      2'd1: return wr ? 16'h8F3F : 16'h8FBF;
      2'd2: return hwv ? 16'h0F6C : 16'h0E6C;
      default: return (wr ? 16'h092F : 16'h09AF) | (hwv ? 16'h7000 : 16'h0000);
    endcase
  endfunction

  task automatic runOne(input logic [11:0] off, input logic [3:0] sz, input logic wr,
                        input logic [1:0] lvl);
    logic eHit, eRaw, eErr, eUndef, eOnes, hw, sw, own, anyB;
    logic [3:0] eSel;
    logic [1:0] ring;
    logic [15:0] m;
    reqValid = 1'b1; reqOffset = off; reqSize = sz; reqWrite = wr; reqLevel = lvl;
    ring = off[5:4];
    own = 1'b1;
    for (int r = 0; r < 4; r++) if (r >= ring) own = own & ringWord2[8*r+7];
    lookOp(off, sz, wr, lvl, eHit, eSel, hw, sw);
    m = byteMask(ring, wr, lvl == 2'd3);
    anyB = 1'b0;
    for (int b = 0; b < 16; b++)
      if (b >= off[3:0] && b < off[3:0] + sz) anyB = anyB | m[b];
    eRaw = 0; eErr = 0; eUndef = 0; eOnes = 0;
    if (eHit) eUndef = own ? !hw : !sw;
    else if (off[11] || sz < 4 || ring == 0 || !anyB) begin eErr = 1; eOnes = !wr; end
    else begin eRaw = 1; eUndef = wr && own; end
    @(negedge clk);
    check(off[11] ? "R3,R10 hit" : "R4,R10 hit", {3'b0, opHit, opSel}, {3'b0, eHit, eSel});
    check("R6,R7 raw", {7'b0, rawEn}, {7'b0, eRaw});
    check(off[11] ? "R3 err" : "R6 err", {6'b0, errFlag, rdOnes}, {6'b0, eErr, eOnes});
    check(eHit ? "R2,R5 undef" : "R2,R8 undef", {7'b0, undefFlag}, {7'b0, eUndef});
  endtask

  initial begin
    #(8ns * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    logic [3:0]  sizes [4];
    pats[0] = 32'h80808080; pats[1] = 32'h00808080;
    pats[2] = 32'h80008080; pats[3] = 32'h80807F00;
    sizes[0] = 1; sizes[1] = 2; sizes[2] = 4; sizes[3] = 8;
    repeat (2) @(negedge clk);
    // R1: outputs low during reset
    check("R1 reset", {2'b0, opHit, rawEn, errFlag, undefFlag, rdOnes, 1'b0}, 8'h00);
    check("R1 reset sel", {4'b0, opSel}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {3'b0, opHit, rawEn, errFlag, undefFlag, rdOnes}, 8'h00);
    for (int p = 0; p < 4; p++) begin
      ringWord2 = pats[p];
      for (int lv = 0; lv < 4; lv++)
        for (int w = 0; w < 2; w++)
          for (int s = 0; s < 4; s++)
            for (int k = 0; k < 128; k++)
              runOne(k < 64 ? 12'(k) : 12'(12'h800 + k - 64), sizes[s], w[0], 2'(lv));
      // R9: idle cycle clears all outputs
      reqValid = 1'b0;
      @(negedge clk);
      check("R9 idle", {3'b0, opHit, rawEn, errFlag, undefFlag, rdOnes}, 8'h00);
      check("R9 idle sel", {4'b0, opSel}, 8'h00);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule